// File: doc/BRIEF.md
# Timed Receive Command Queue

This block takes receive-streaming commands from software and hands them, one at a time, to a sample-capture controller. A command is built from three register writes: a control word, a seconds timestamp and a ticks timestamp. The control word carries a start-immediately flag, a continue-stream flag and a 30-bit sample count. Only the ticks write commits the command. At that point the three words enter a small queue as a single entry, and a control or seconds write on its own never queues anything.

A sequencer looks at the oldest queued entry. An immediate command is offered to the capture side at once. A timed command is offered when the local {seconds, ticks} time equals its timestamp. If that time has already passed, the entry is discarded and a late flag is raised. The offer uses a valid/ready handshake. While `cap_valid` is high and `cap_ready` is low, the count and chain outputs are held stable, and the offer completes on the first cycle that both are high. The capture side then runs the command and pulses `cap_done` when it has finished.

If the finished command had its continue flag set, the next queued entry is offered on the following cycle and its timestamp is not examined. If no entry is waiting at that point, a broken-chain flag is raised. A commit into a full queue is dropped and raises an overflow flag. All three flags are sticky, and `irq` is their OR. A synchronous `clear` empties the queue, drops any offer, clears the flags and returns the sequencer to idle.

Top module: `rxcmd_sched`

## Requirements
- R1: A write with `wr_sel`=2 (ticks) commits one entry. It is formed from the last control word (`wr_sel`=0) and the last seconds word (`wr_sel`=1) together with the ticks data. Control or seconds writes alone, and writes with `wr_sel`=3, queue nothing.
- R2: In the control word, bit 31 is the immediate flag, bit 30 is the chain flag and bits 29:0 are the sample count. An immediate entry is offered one cycle after its commit edge, whatever the time, with `cap_count` equal to bits 29:0 and `cap_chain` equal to bit 30.
- R3: A timed entry is offered on the edge after the first cycle in which the {seconds, ticks} time equals its stamp. Seconds are compared first and ticks second.
- R4: A timed entry whose stamp is earlier than the current time is removed without being offered. It sets `err_late`, which then stays set.
- R5: While `cap_valid` is high and `cap_ready` is low, `cap_valid`, `cap_count` and `cap_chain` hold their values.
- R6: When `cap_done` arrives for a chained command and an entry is queued, that entry is offered on the next cycle regardless of its timestamp.
- R7: When `cap_done` arrives for a chained command and the queue is empty, `err_chain` is set and stays set.
- R8: When `cap_done` arrives for a non-chained command, the sequencer returns to idle, and the next entry waits for its own start condition.
- R9: A commit while the queue holds DEPTH entries is dropped and sets `err_ovf`, which stays set. The entries already stored are kept.
- R10: `clear` empties the queue, drops `cap_valid`, and clears all three flags.
- R11: `irq` is high exactly when at least one of `err_late`, `err_chain` or `err_ovf` is high.
- R12: Entries are offered in commit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous flush of queue, sequencer and flags |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Word select: 0 control, 1 seconds, 2 ticks (commit), 3 unused |
| wr_data | input | 32 | Write data |
| time_secs | input | 32 | Current local time, seconds |
| time_ticks | input | 32 | Current local time, ticks |
| cap_valid | output | 1 | Command offered to the capture side |
| cap_ready | input | 1 | Capture side accepts the offer |
| cap_count | output | 30 | Sample count of the offered or running command |
| cap_chain | output | 1 | Chain flag of the offered or running command |
| cap_done | input | 1 | Capture side has finished the running command |
| err_late | output | 1 | Sticky: a timed command was discarded as late |
| err_chain | output | 1 | Sticky: a chain ended with no successor queued |
| err_ovf | output | 1 | Sticky: a commit was dropped because the queue was full |
| irq | output | 1 | OR of the three error flags |

## Verification
The commit lands in the queue on the ticks-write edge. An immediate or time-matched entry raises `cap_valid` on the next edge, so the bench samples it at the falling edge that follows that second edge. A late discard and an overflow set their flags at the deciding edge. A chained successor appears at the edge that samples `cap_done`, so the bench checks it at the falling edge right after the done pulse. The timed sweep moves the time one tick per cycle and requires `cap_valid` to be low in every cycle before the match and high in the match cycle itself. This pins the latency to the exact cycle rather than to an eventual event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 30;
  localparam int TIME_W = 32;
  localparam int NOW_BIT   = WORD_W - 1;
  localparam int CHAIN_BIT = WORD_W - 2;

  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_SECS  = 2'd1;
  localparam logic [1:0] SEL_TICKS = 2'd2;

  typedef struct packed {
    logic              now;
    logic              chain;
    logic [CNT_W-1:0]  count;
    logic [TIME_W-1:0] secs;
    logic [TIME_W-1:0] ticks;
  } rx_cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_RUN} seq_st_e;

  // Returns {stamp_in_past, stamp_equal}
  function automatic logic [1:0] time_rel(
    input logic [TIME_W-1:0] cur_s, input logic [TIME_W-1:0] cur_t,
    input logic [TIME_W-1:0] ts_s,  input logic [TIME_W-1:0] ts_t);
    logic past, eq;
    eq   = (cur_s == ts_s) && (cur_t == ts_t);
    past = (cur_s > ts_s) || ((cur_s == ts_s) && (cur_t > ts_t));
    return {past, eq};
  endfunction
endpackage

// File: rtl/rxq_stage.sv
module rxq_stage
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              push,
  output rx_cmd_t           entry
);
  logic [WORD_W-1:0] ctl_q;
  logic [TIME_W-1:0] secs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ctl_q  <= '0;
      secs_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CMD)  ctl_q  <= wr_data;
      if (wr_sel == SEL_SECS) secs_q <= wr_data[TIME_W-1:0];
    end
  end

  always_comb begin
    push        = wr_en && (wr_sel == SEL_TICKS) && !clear;
    entry.now   = ctl_q[NOW_BIT];
    entry.chain = ctl_q[CHAIN_BIT];
    entry.count = ctl_q[CNT_W-1:0];
    entry.secs  = secs_q;
    entry.ticks = wr_data[TIME_W-1:0];
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 94,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         head_vld,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign head_vld = (cnt != '0);
  assign full     = (cnt == FULL_N);
  assign dout     = mem[rd_p];
  assign do_pop   = pop && head_vld;
  assign do_push  = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (do_push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
      if (do_pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && !do_push) ovf <= 1'b1;
    end
  end

  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_vld);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clear) |=> (ovf && full));
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_N);
endmodule

// File: rtl/rxq_seq.sv
module rxq_seq
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [TIME_W-1:0] time_secs,
  input  logic [TIME_W-1:0] time_ticks,
  input  rx_cmd_t           head,
  input  logic              head_vld,
  output logic              pop,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [CNT_W-1:0]  cap_count,
  output logic              cap_chain,
  input  logic              cap_done,
  output logic              err_late,
  output logic              err_chain
);
  seq_st_e    st;
  logic [1:0] rel;
  logic       idle_go, idle_late, chain_go, chain_break, run_end;

  assign rel = time_rel(time_secs, time_ticks, head.secs, head.ticks);

  always_comb begin
    idle_go     = (st == ST_IDLE) && head_vld && (head.now || rel[0]);
    idle_late   = (st == ST_IDLE) && head_vld && !head.now && rel[1];
    chain_go    = (st == ST_RUN) && cap_done && cap_chain && head_vld;
    chain_break = (st == ST_RUN) && cap_done && cap_chain && !head_vld;
    run_end     = (st == ST_RUN) && cap_done && !cap_chain;
    pop         = !clear && (idle_go || idle_late || chain_go);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      st        <= ST_IDLE;
      cap_valid <= 1'b0;
      cap_count <= '0;
      cap_chain <= 1'b0;
      err_late  <= 1'b0;
      err_chain <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (idle_go) begin
            st        <= ST_OFFER;
            cap_valid <= 1'b1;
            cap_count <= head.count;
            cap_chain <= head.chain;
          end else if (idle_late) begin
            err_late <= 1'b1;
          end
        end
        ST_OFFER: begin
          if (cap_ready) begin
            st        <= ST_RUN;
            cap_valid <= 1'b0;
          end
        end
        ST_RUN: begin
          if (chain_go) begin
            st        <= ST_OFFER;
            cap_valid <= 1'b1;
            cap_count <= head.count;
            cap_chain <= head.chain;
          end else if (chain_break) begin
            st        <= ST_IDLE;
            err_chain <= 1'b1;
          end else if (run_end) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready && !clear) |=> (cap_valid && $stable(cap_count) && $stable(cap_chain)));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!cap_valid && !err_late && !err_chain));
  p_late_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_late && !clear) |=> err_late);
  p_chain_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_chain && !clear) |=> err_chain);
  p_valid_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> $past(pop));
endmodule

// File: rtl/rxcmd_sched.sv
module rxcmd_sched
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] time_secs,
  input  logic [31:0] time_ticks,
  output logic        cap_valid,
  input  logic        cap_ready,
  output logic [29:0] cap_count,
  output logic        cap_chain,
  input  logic        cap_done,
  output logic        err_late,
  output logic        err_chain,
  output logic        err_ovf,
  output logic        irq
);
  localparam int ENT_W = $bits(rx_cmd_t);

  logic       push, pop, head_vld, full;
  rx_cmd_t    stage_ent, head;
  logic [ENT_W-1:0] head_bits;

  rxq_stage u_stage (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .push(push), .entry(stage_ent)
  );

  rxq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push(push), .din(stage_ent), .pop(pop),
    .dout(head_bits), .head_vld(head_vld), .full(full), .ovf(err_ovf)
  );

  assign head = rx_cmd_t'(head_bits);

  rxq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .time_secs(time_secs), .time_ticks(time_ticks),
    .head(head), .head_vld(head_vld), .pop(pop),
    .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_count(cap_count), .cap_chain(cap_chain), .cap_done(cap_done),
    .err_late(err_late), .err_chain(err_chain)
  );

  assign irq = err_late | err_chain | err_ovf;

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovf) |-> irq);
endmodule

// File: tb/sim_rxcmd_sched.sv
module sim_rxcmd_sched;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0, tsec = '0, ttick = '0;
  logic cap_ready = 1'b0, cap_done = 1'b0;
  logic cap_valid, cap_chain, err_late, err_chain, err_ovf, irq;
  logic [29:0] cap_count;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  rxcmd_sched #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .time_secs(tsec), .time_ticks(ttick),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_count(cap_count),
    .cap_chain(cap_chain), .cap_done(cap_done), .err_late(err_late),
    .err_chain(err_chain), .err_ovf(err_ovf), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc1(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit(input bit nw, input bit ch, input logic [29:0] cnt,
                        input logic [31:0] s, input logic [31:0] t);
    wr(2'd0, {nw, ch, cnt});
    wr(2'd1, s);
    wr(2'd2, t);
  endtask

  task automatic accept(); cap_ready = 1'b1; @(negedge clk); cap_ready = 1'b0; endtask
  task automatic done();   cap_done  = 1'b1; @(negedge clk); cap_done  = 1'b0; endtask
  task automatic flush();  clear     = 1'b1; @(negedge clk); clear     = 1'b0; endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc1();
    chk(!cap_valid && !irq && !err_late && !err_chain && !err_ovf, "reset R10", cap_valid, 0);

    // R1: partial writes and unused select queue nothing
    tsec = 32'd50; ttick = 32'd0;
    wr(2'd0, {1'b1, 1'b0, 30'd9});
    wr(2'd1, 32'd1);
    wr(2'd3, 32'd77);
    repeat (3) cyc1();
    chk(!cap_valid, "R1 no commit without ticks write", cap_valid, 0);
    wr(2'd2, 32'd0);
    chk(!cap_valid, "R1 offer not before next edge", cap_valid, 0);
    cyc1();
    chk(cap_valid && cap_count == 30'd9, "R1 commit on ticks write", cap_count, 9);
    accept(); done();

    // R2: immediate sweep over counts, stamp in the past is ignored
    for (int i = 0; i < 8; i++) begin
      logic [29:0] c;
      c = (i == 7) ? 30'h3FFF_FFFF : 30'((64'd1 << (4 * i + 2)) - 1);
      commit(1'b1, 1'b0, c, 32'd1, 32'd1);
      cyc1();
      chk(cap_valid && cap_count == c && !cap_chain, "R2 immediate offer", cap_count, c);
      accept(); done();
    end
    chk(!err_late, "R2 immediate never late", err_late, 0);

    // R3: timed, time advances one tick per cycle
    for (int d = 1; d <= 4; d++) begin
      tsec = 32'd5; ttick = 32'd1000;
      commit(1'b0, 1'b0, 30'(100 + d), 32'd5, 32'd1000 + d);
      for (int k = 1; k <= d; k++) begin
        ttick = 32'd1000 + k;
        cyc1();
        chk(cap_valid == (k == d), "R3 offer at exact match", cap_valid, k == d);
      end
      chk(cap_count == 30'(100 + d), "R3 timed count", cap_count, 100 + d);
      accept(); done();
    end
    // R3: seconds dominate ticks
    tsec = 32'd5; ttick = 32'hFFFF_FF00;
    commit(1'b0, 1'b0, 30'd33, 32'd6, 32'd0);
    repeat (2) cyc1();
    chk(!cap_valid && !err_late, "R3 later second waits", cap_valid, 0);
    tsec = 32'd6; ttick = 32'd0;
    repeat (2) cyc1();
    chk(cap_valid && cap_count == 30'd33, "R3 second rollover match", cap_count, 33);

    // R5: back-pressure holds the offer
    repeat (3) cyc1();
    chk(cap_valid && cap_count == 30'd33, "R5 held under back-pressure", cap_count, 33);
    accept();
    chk(!cap_valid, "R5 offer ends on handshake", cap_valid, 0);
    done();

    // R4: late entries discarded
    tsec = 32'd7; ttick = 32'd500;
    commit(1'b0, 1'b0, 30'd44, 32'd7, 32'd499);
    cyc1();
    chk(!cap_valid && err_late, "R4 late flag", err_late, 1);
    chk(irq, "R11 irq on late", irq, 1);
    flush();
    chk(!err_late && !irq, "R10 clear drops flags", err_late, 0);
    commit(1'b0, 1'b0, 30'd45, 32'd6, 32'd900);
    commit(1'b1, 1'b0, 30'd46, 32'd0, 32'd0);
    cyc1();
    chk(err_late && cap_valid && cap_count == 30'd46, "R4 late entry removed", cap_count, 46);
    accept(); done(); flush();

    // R6: chained successor offered after done, its stamp ignored
    commit(1'b1, 1'b1, 30'd5, 32'd0, 32'd0);
    commit(1'b0, 1'b0, 30'd7, 32'hFFFF_FFFF, 32'd0);
    chk(cap_valid && cap_count == 30'd5 && cap_chain, "R6 chain head", cap_count, 5);
    accept(); done();
    chk(cap_valid && cap_count == 30'd7 && !cap_chain, "R6 successor no gap", cap_count, 7);
    accept(); done();
    repeat (2) cyc1();
    chk(!err_chain && !cap_valid, "R8 non-chained end idles", err_chain, 0);

    // R8: after a non-chained end a timed entry waits
    commit(1'b0, 1'b0, 30'd8, 32'd99, 32'd0);
    repeat (3) cyc1();
    chk(!cap_valid, "R8 next entry waits for its time", cap_valid, 0);
    flush();

    // R7: broken chain
    commit(1'b1, 1'b1, 30'd3, 32'd0, 32'd0);
    cyc1(); accept(); done();
    chk(err_chain && irq && !cap_valid, "R7 broken chain", err_chain, 1);

    // R10: clear drops an offer and empties the queue
    flush();
    commit(1'b0, 1'b0, 30'd60, 32'd200, 32'd0);
    commit(1'b1, 1'b0, 30'd61, 32'd0, 32'd0);
    flush();
    tsec = 32'd200; ttick = 32'd0;
    repeat (3) cyc1();
    chk(!cap_valid && !irq, "R10 queue emptied", cap_valid, 0);
    tsec = 32'd0;
    commit(1'b1, 1'b0, 30'd62, 32'd0, 32'd0);
    cyc1();
    flush();
    chk(!cap_valid, "R10 clear drops offer", cap_valid, 0);

    // R9/R12: fill beyond depth, then release in order
    for (int n = 0; n <= DEPTH; n++) begin
      commit(1'b0, 1'b0, 30'(11 + n), 32'd300, 32'd0);
      chk(err_ovf == (n == DEPTH), "R9 overflow on extra commit", err_ovf, n == DEPTH);
    end
    chk(irq, "R11 irq on overflow", irq, 1);
    tsec = 32'd300; ttick = 32'd0;
    for (int n = 0; n < DEPTH; n++) begin
      cyc1();
      chk(cap_valid && cap_count == 30'(11 + n), "R12 commit order", cap_count, 11 + n);
      accept(); done();
    end
    repeat (3) cyc1();
    chk(!cap_valid && err_ovf, "R9 dropped entry absent", cap_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule